// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a multi-channel timer. A shared free-running or modulo counter, built outside this block, feeds every channel with its count value and a one-cycle overflow pulse. Each channel is set up independently. In capture mode it watches an external pin and stores the count when a chosen edge arrives. In compare mode it drives an output pin whenever the count equals a programmed value. Every channel has a sticky event flag.

In compare mode the match can set, clear or toggle the pin, or leave it alone. The pin can also toggle on each counter overflow, and a match in the same cycle takes priority over that toggle. Together these features produce PWM waveforms. A new compare value can take effect at once (unbuffered). It can also wait in a shadow register until the next overflow (buffered), so that a duty-cycle change never lands in the middle of a period.

All pins are plain level or pulse controls. No stream interfaces are present, so there is no back-pressure. The counter value, the overflow pulse and the register writes are sampled on every rising clock edge.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `out_o`, `flag_o`, `cap_o` and `cmp_act_o` are all zero.
- R2: In capture mode (`mode_i`=0), an accepted pin edge updates `cap_o` on the third rising clock after the pin changes, and `flag_o` is set on the same edge. The pin passes through two synchronizer flops before edge detection. The stored value is the `cnt_i` present in the cycle just before that third edge.
- R3: `edge_sel_i` chooses the capture edge: 01 rising, 10 falling, 11 either, 00 none. An edge that is not selected leaves both `cap_o` and `flag_o` unchanged.
- R4: In compare mode (`mode_i`=1), when `cnt_i` equals `cmp_act_o` at a rising edge, that edge updates `out_o` according to `act_sel_i`: 00 unchanged, 01 clear, 10 set, 11 toggle. The same edge sets `flag_o`.
- R5: In compare mode with `ovf_tgl_i`=1, a cycle with `ovf_i`=1 and no match inverts `out_o` at that edge.
- R6: When a match and an overflow toggle fall in the same cycle, only the match action is applied.
- R7: With `buf_en_i`=0, a write (`cmp_wr_i`=1) makes `cmp_act_o` equal to `cmp_wdata_i` from the write edge onward.
- R8: With `buf_en_i`=1, a write goes into a shadow register and `cmp_act_o` stays unchanged. The shadow is copied to `cmp_act_o` at the first edge where `ovf_i`=1.
- R9: `flag_o` stays set until an edge with `flag_clr_i`=1 and no new event. When an event and a clear arrive in the same cycle, the flag stays set.
- R10: While `en_i`=0, `out_o` holds its value, `flag_o` is never set, and `cap_o` is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| mode_i | input | 1 | 0 = capture, 1 = compare |
| cnt_i | input | 16 | Shared counter value |
| ovf_i | input | 1 | Counter overflow pulse |
| edge_sel_i | input | 2 | Capture edge select |
| act_sel_i | input | 2 | Compare pin action |
| ovf_tgl_i | input | 1 | Toggle pin on overflow |
| buf_en_i | input | 1 | Buffered compare update |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value to write |
| flag_clr_i | input | 1 | Write-one-to-clear of the flag |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| out_o | output | 1 | Compare output pin |
| cap_o | output | 16 | Captured counter value |
| cmp_act_o | output | 16 | Active compare value |
| flag_o | output | 1 | Sticky channel event flag |

## Verification
Compare results, overflow toggles, compare writes and flag clears are registered once. They are due on the same rising edge that samples their cause. A capture lands on the third edge after the pin change, because of the two-flop synchronizer and the registered edge detector. The bench drives inputs and samples outputs one time unit after each rising edge. It counts edges explicitly, and for a capture it steps the counter on every edge so that the expected value is the count presented before the third edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_CLR  = 2'b01,
    PIN_SET  = 2'b10,
    PIN_TGL  = 2'b11
  } pin_act_e;
endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import tmr_chan_pkg::*;

  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], pin_i};
  end

  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          buf_i,
  input  logic          ovf_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] act_o,
  output logic          match_o
);
  logic [CW-1:0] shadow;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      pend   <= 1'b0;
      act_o  <= '0;
    end else begin
      if (wr_i && !buf_i) begin
        act_o <= wdata_i;
        pend  <= 1'b0;
      end else begin
        if (ovf_i && pend) begin
          act_o <= shadow;
          pend  <= 1'b0;
        end
        if (wr_i) begin
          shadow <= wdata_i;
          pend   <= 1'b1;
        end
      end
    end
  end

  assign match_o = (cnt_i == act_o);

  // R8
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && buf_i && !ovf_i) |=> $stable(act_o));
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       match_i,
  input  logic       ovf_i,
  input  logic       ovf_tgl_i,
  input  logic [1:0] act_sel_i,
  output logic       out_o
);
  import tmr_chan_pkg::*;

  logic nxt;

  always_comb begin
    nxt = out_o;
    if (en_i) begin
      if (match_i) begin
        unique case (pin_act_e'(act_sel_i))
          PIN_CLR: nxt = 1'b0;
          PIN_SET: nxt = 1'b1;
          PIN_TGL: nxt = ~out_o;
          default: nxt = out_o;
        endcase
      end else if (ovf_i && ovf_tgl_i) begin
        nxt = ~out_o;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_o <= 1'b0;
    else        out_o <= nxt;
  end

  // R4
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && match_i && act_sel_i == 2'b10) |=> out_o);
  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(out_o));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ovf_i,
  input  logic [1:0]    edge_sel_i,
  input  logic [1:0]    act_sel_i,
  input  logic          ovf_tgl_i,
  input  logic          buf_en_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] cmp_wdata_i,
  input  logic          flag_clr_i,
  input  logic          cap_pin_i,
  output logic          out_o,
  output logic [CW-1:0] cap_o,
  output logic [CW-1:0] cmp_act_o,
  output logic          flag_o
);
  logic edge_hit, match, cap_ev, cmp_ev, cmp_on;

  tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_u (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .sel_i(edge_sel_i), .hit_o(edge_hit)
  );

  tmr_chan_cmp #(.CW(CW)) cmp_u (
    .clk(clk), .rst_n(rst_n), .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i), .buf_i(buf_en_i),
    .ovf_i(ovf_i), .cnt_i(cnt_i), .act_o(cmp_act_o), .match_o(match)
  );

  assign cmp_on = en_i & mode_i;

  tmr_chan_out out_u (
    .clk(clk), .rst_n(rst_n), .en_i(cmp_on), .match_i(match), .ovf_i(ovf_i),
    .ovf_tgl_i(ovf_tgl_i), .act_sel_i(act_sel_i), .out_o(out_o)
  );

  assign cap_ev = en_i & ~mode_i & edge_hit;
  assign cmp_ev = cmp_on & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (cap_ev) cap_o <= cnt_i;
      if (cap_ev || cmp_ev) flag_o <= 1'b1;
      else if (flag_clr_i)  flag_o <= 1'b0;
    end
  end

  // R2
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (cap_o == $past(cnt_i)));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_ev && !cmp_ev) |=> !flag_o);
  // R10
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !flag_clr_i) |=> $stable(flag_o));
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        en_i = 0, mode_i = 0, ovf_i = 0, ovf_tgl_i = 0, buf_en_i = 0;
  logic        cmp_wr_i = 0, flag_clr_i = 0, cap_pin_i = 0;
  logic [15:0] cnt_i = 0, cmp_wdata_i = 0;
  logic [1:0]  edge_sel_i = 0, act_sel_i = 0;
  logic        out_o, flag_o;
  logic [15:0] cap_o, cmp_act_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_chan dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i), .cnt_i(cnt_i), .ovf_i(ovf_i),
    .edge_sel_i(edge_sel_i), .act_sel_i(act_sel_i), .ovf_tgl_i(ovf_tgl_i), .buf_en_i(buf_en_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i), .flag_clr_i(flag_clr_i),
    .cap_pin_i(cap_pin_i), .out_o(out_o), .cap_o(cap_o), .cmp_act_o(cmp_act_o), .flag_o(flag_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin change then three edges with the counter stepping each edge
  task automatic cap_run(logic lvl, logic [15:0] c, logic hit, logic [15:0] old);
    cap_pin_i = lvl; cnt_i = c;
    tick(); cnt_i = c + 1;
    tick(); cnt_i = c + 2;
    check("R2 no early capture", cap_o, old);
    tick();
    check("R2/R3 capture value", cap_o, hit ? c + 16'd2 : old);
  endtask

  task automatic clr_flag();
    flag_clr_i = 1; tick(); flag_clr_i = 0;
  endtask

  task automatic t_reset();
    check("R1 out", out_o, 0);
    check("R1 flag", flag_o, 0);
    check("R1 cap", cap_o, 0);
    check("R1 cmp", cmp_act_o, 0);
  endtask

  task automatic t_capture();
    en_i = 1; mode_i = 0; edge_sel_i = 2'b01;
    cap_run(1, 16'h0100, 1, 16'h0000);
    check("R2 flag set", flag_o, 1);
    clr_flag();
    check("R9 flag cleared", flag_o, 0);
    cap_run(0, 16'h0200, 0, 16'h0102);          // R3 falling ignored under rising
    check("R3 flag untouched", flag_o, 0);
    edge_sel_i = 2'b10;
    cap_run(1, 16'h0300, 0, 16'h0102);
    cap_run(0, 16'h0400, 1, 16'h0102);          // R3 falling accepted
    edge_sel_i = 2'b11;
    cap_run(1, 16'h0500, 1, 16'h0402);
    cap_run(0, 16'h0600, 1, 16'h0502);
    clr_flag();
    edge_sel_i = 2'b00;
    cap_run(1, 16'h0700, 0, 16'h0602);
    check("R3 none leaves flag", flag_o, 0);
  endtask

  task automatic t_compare();
    mode_i = 1; cnt_i = 16'd1;
    cmp_wr_i = 1; cmp_wdata_i = 16'd100; tick(); cmp_wr_i = 0;
    check("R7 unbuffered write", cmp_act_o, 100);
    clr_flag();
    act_sel_i = 2'b10; cnt_i = 99; tick();
    check("R4 no match keeps pin", out_o, 0);
    cnt_i = 100; tick();
    check("R4 set", out_o, 1);
    check("R4 flag", flag_o, 1);
    act_sel_i = 2'b01; tick();
    check("R4 clear", out_o, 0);
    act_sel_i = 2'b11; tick();
    check("R4 toggle", out_o, 1);
    tick();
    check("R4 toggle again", out_o, 0);
    act_sel_i = 2'b00; tick();
    check("R4 keep", out_o, 0);
  endtask

  task automatic t_overflow();
    act_sel_i = 2'b10; ovf_tgl_i = 1; cnt_i = 5; ovf_i = 1; tick(); ovf_i = 0;
    check("R5 overflow toggle", out_o, 1);
    cnt_i = 100; ovf_i = 1; tick(); ovf_i = 0;
    check("R6 match wins", out_o, 1);
    ovf_tgl_i = 0; cnt_i = 5; ovf_i = 1; tick(); ovf_i = 0;
    check("R5 toggle disabled", out_o, 1);
  endtask

  task automatic t_buffered();
    buf_en_i = 1; cnt_i = 5;
    cmp_wr_i = 1; cmp_wdata_i = 16'd200; tick(); cmp_wr_i = 0;
    check("R8 held in shadow", cmp_act_o, 100);
    tick();
    check("R8 still held", cmp_act_o, 100);
    ovf_i = 1; tick(); ovf_i = 0;
    check("R8 loaded at overflow", cmp_act_o, 200);
    buf_en_i = 0;
  endtask

  task automatic t_flag_disable();
    act_sel_i = 2'b11; cnt_i = 200; flag_clr_i = 1; tick(); flag_clr_i = 0;
    check("R9 set beats clear", flag_o, 1);
    cnt_i = 5; clr_flag();
    check("R9 cleared", flag_o, 0);
    en_i = 0; cnt_i = 200; tick();
    check("R10 pin holds", out_o, 0);
    check("R10 no flag", flag_o, 0);
    mode_i = 0; edge_sel_i = 2'b11;
    cap_run(1, 16'h0900, 0, 16'h0602);
    check("R10 no capture flag", flag_o, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_capture();
    t_compare();
    t_overflow();
    t_buffered();
    t_flag_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule